// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings a 2048-row fast page mode DRAM out of power-up and then keeps it refreshed. After reset it waits out a start-up pause, long enough for the supply and the array to settle. It then runs a burst of wake-up cycles, and only after that reports the memory as ready. From then on it raises a refresh request at a fixed interval. Each refresh is a CAS-before-RAS cycle that the block drives onto the strobe pins itself once the access controller grants the bus.

The block talks to the access controller through a request/grant pair. It holds the request high while it has work queued or while one of its own cycles is on the pins, and the controller keeps its hands off the strobes while both are high. Refresh ticks that cannot be served at once are counted, up to a fixed depth, and issued back to back when the grant returns. A sticky flag reports a tick lost because that count was full. The DRAM needs a fresh wake-up burst after a long stretch without any RAS activity. For that case an idle detector withdraws the ready flag and reruns the wake-up burst. The wake-up cycles use the same CAS-before-RAS waveform as regular refreshes, so no row address is ever needed.

Top module: `dram_rfsh_sched`

## Requirements
- R1: For PAUSE_CYC clock cycles after reset is released, ref_req stays low and ras_n and cas_n stay high. ref_req rises on the clock edge that ends the pause.
- R2: After the pause, exactly WAKE_CYCLES refresh cycles are issued with init_done low. init_done rises only once the last of them has left the pins.
- R3: In every cycle, cas_n falls exactly CAS_LEAD clock cycles before ras_n falls. cas_n stays low for as long as ras_n is low, and both rise on the same edge.
- R4: ras_n stays low for exactly RAS_LOW clock cycles. After it rises, both strobes stay high for at least PRECHG cycles before cas_n falls again.
- R5: No cycle starts unless ref_gnt and ref_req were both high on the edge that starts it. While ref_gnt is low and no cycle is running, both strobes stay high.
- R6: Once ready, with the grant held high, successive falls of ras_n are exactly REFI_CYC clock cycles apart.
- R7: Refresh ticks that arrive while the grant is withheld are counted, up to PEND_MAX of them. When the grant returns they are issued back to back, each ras_n fall CAS_LEAD+RAS_LOW+PRECHG+1 cycles after the one before.
- R8: A tick that arrives while PEND_MAX refreshes are already waiting sets pend_ovf. pend_ovf then stays high until reset, and the waiting count stays at PEND_MAX.
- R9: If the ready block issues no cycle for IDLE_LIMIT_CYC clock cycles, init_done falls. WAKE_CYCLES wake-up cycles, issued with init_done low, must then complete before it rises again.
- R10: ref_req is high whenever wake-up or refresh work is waiting, and throughout every cycle the block drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant of the strobe pins from the access controller |
| ref_req | output | 1 | Request for the strobe pins; high while work waits or a cycle runs |
| ras_n | output | 1 | Row strobe, active low, to the pin multiplexer |
| cas_n | output | 1 | Column strobe for all byte lanes, active low, to the pin multiplexer |
| init_done | output | 1 | High when the DRAM may be used for accesses |
| pend_ovf | output | 1 | Sticky flag: a refresh tick was lost to a full queue |

## Verification
The assertions check on every cycle the rules that hold at any single edge. These are the quiet strobes during the pause, CAS leading and covering RAS, no cycle starting without a grant, no cycle running while ready rises, the queue bound and the sticky error flag. Other behaviours can only be shown by the bench's scenarios, because they depend on counts over long spans of cycles. These are the exact pause length, the number of wake-up cycles before ready, the refresh spacing under a held grant, the back-to-back spacing of a drained queue, and the drop of ready followed by a rerun of the wake-up burst after a long idle stretch.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    CY_IDLE = 2'd0,
    CY_CAS  = 2'd1,
    CY_RAS  = 2'd2,
    CY_PRE  = 2'd3
  } cyc_st_t;

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int REFI_CYC = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = TW'(REFI_CYC - 1);
    else if (tick) cnt_d = TW'(REFI_CYC - 1);
    else           cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TW'(REFI_CYC - 1);
    else        cnt_q <= cnt_d;
  end

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nz,
  output logic ovf
);
  localparam int CW = $clog2(PEND_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full;

  assign full = (cnt_q == CW'(PEND_MAX));
  assign nz   = (cnt_q != '0);
  assign ovf  = ovf_q;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (inc && !dec) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc && nz) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R7
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PEND_MAX));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/cbr_engine.sv
module cbr_engine
  import dram_rfsh_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 6,
  parameter int PRECHG   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic cas_n
);
  localparam int LMAX = (CAS_LEAD > RAS_LOW) ?
                        ((CAS_LEAD > PRECHG) ? CAS_LEAD : PRECHG) :
                        ((RAS_LOW  > PRECHG) ? RAS_LOW  : PRECHG);
  localparam int CW = $clog2(LMAX + 1);

  cyc_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy  = (st_q != CY_IDLE);
  assign cas_n = !((st_q == CY_CAS) || (st_q == CY_RAS));
  assign ras_n = !(st_q == CY_RAS);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      CY_IDLE: if (start) begin
        st_d  = CY_CAS;
        cnt_d = CW'(CAS_LEAD - 1);
      end
      CY_CAS: if (cnt_q == '0) begin
        st_d  = CY_RAS;
        cnt_d = CW'(RAS_LOW - 1);
      end else cnt_d = cnt_q - 1'b1;
      CY_RAS: if (cnt_q == '0) begin
        st_d  = CY_PRE;
        cnt_d = CW'(PRECHG - 1);
      end else cnt_d = cnt_q - 1'b1;
      CY_PRE: if (cnt_q == '0) st_d = CY_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: st_d = CY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CY_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R3
  cas_covers_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC      = 50000,
  parameter int WAKE_CYCLES    = 8,
  parameter int REFI_CYC       = 1500,
  parameter int IDLE_LIMIT_CYC = 3200000,
  parameter int PEND_MAX       = 4,
  parameter int CAS_LEAD       = 1,
  parameter int RAS_LOW        = 6,
  parameter int PRECHG         = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic pend_ovf
);
  localparam int PW = (PAUSE_CYC > 2) ? $clog2(PAUSE_CYC) : 1;
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam int IW = (IDLE_LIMIT_CYC > 2) ? $clog2(IDLE_LIMIT_CYC) : 1;

  phase_t        ph_q, ph_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [WW-1:0] wake_q, wake_d;
  logic [IW-1:0] idle_q, idle_d;

  logic busy, work, issue, tick, pend_nz;

  assign work = ((ph_q == PH_WAKE) && (wake_q != '0)) ||
                ((ph_q == PH_RUN) && pend_nz);
  assign issue     = work && ref_gnt && !busy;
  assign ref_req   = work || busy;
  assign init_done = (ph_q == PH_RUN);

  rfsh_interval #(.REFI_CYC(REFI_CYC)) i_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ph_q == PH_RUN),
    .tick (tick)
  );

  rfsh_pend #(.PEND_MAX(PEND_MAX)) i_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (tick),
    .dec  (issue && (ph_q == PH_RUN)),
    .nz   (pend_nz),
    .ovf  (pend_ovf)
  );

  cbr_engine #(
    .CAS_LEAD(CAS_LEAD),
    .RAS_LOW (RAS_LOW),
    .PRECHG  (PRECHG)
  ) i_engine (
    .clk  (clk),
    .rst_n(rst_n),
    .start(issue),
    .busy (busy),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  always_comb begin
    ph_d    = ph_q;
    pause_d = pause_q;
    wake_d  = wake_q;
    idle_d  = idle_q;
    case (ph_q)
      PH_PAUSE: begin
        if (pause_q == '0) begin
          ph_d   = PH_WAKE;
          wake_d = WW'(WAKE_CYCLES);
        end else pause_d = pause_q - 1'b1;
      end
      PH_WAKE: begin
        if (issue) wake_d = wake_q - 1'b1;
        else if ((wake_q == '0) && !busy) begin
          ph_d   = PH_RUN;
          idle_d = '0;
        end
      end
      PH_RUN: begin
        if (issue) idle_d = '0;
        else if (idle_q == IW'(IDLE_LIMIT_CYC - 1)) begin
          ph_d   = PH_WAKE;
          wake_d = WW'(WAKE_CYCLES);
        end else idle_d = idle_q + 1'b1;
      end
      default: ph_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_PAUSE;
      pause_q <= PW'(PAUSE_CYC - 1);
      wake_q  <= '0;
      idle_q  <= '0;
    end else begin
      ph_q    <= ph_d;
      pause_q <= pause_d;
      wake_q  <= wake_d;
      idle_q  <= idle_d;
    end
  end

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PAUSE) |-> (!ref_req && ras_n && cas_n));

  // R5
  grant_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($past(ref_gnt) && $past(ref_req)));

  // R2
  ready_on_quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ras_n && cas_n));

  // R10
  req_during_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ref_req);

endmodule

// File: tb/test_dram_rfsh_sched.sv
module test_dram_rfsh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE_CYC  = 40;
  localparam int WAKE_CYC   = 8;
  localparam int REFI       = 60;
  localparam int IDLE_LIM   = 500;
  localparam int PEND_MAX   = 4;
  localparam int CAS_LEAD   = 1;
  localparam int RAS_LOW    = 6;
  localparam int PRECHG     = 4;
  localparam int B2B        = CAS_LEAD + RAS_LOW + PRECHG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ras_n, cas_n, init_done, pend_ovf;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int n_fall = 0;
  int fall_cyc = 0;
  event fall_ev;
  bit exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rfsh_sched #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_CYCLES(WAKE_CYC), .REFI_CYC(REFI),
    .IDLE_LIMIT_CYC(IDLE_LIM), .PEND_MAX(PEND_MAX),
    .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .PRECHG(PRECHG)
  ) i_dram_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done), .pend_ovf(pend_ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures every strobe waveform and pops the scoreboard at each RAS fall
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int cas_lead = 0, ras_low = 0, hi_cnt = 0;
  bit seen_rise = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_ras && !ras_n) begin
        chk(cas_lead == CAS_LEAD, "R3", "CAS lead before RAS fall", cas_lead, CAS_LEAD);
        if (exp_q.size() > 0) begin
          bit e;
          e = exp_q.pop_front();
          chk(init_done == e, "R2", "init_done at wake-up RAS fall", int'(init_done), int'(e));
        end else begin
          chk(init_done == 1'b1, "R9", "refresh outside wake-up only when ready",
              int'(init_done), 1);
        end
        n_fall++;
        fall_cyc = cyc;
        ras_low = 0;
        -> fall_ev;
      end
      if (!prev_ras && ras_n) begin
        chk(ras_low == RAS_LOW, "R4", "RAS low width", ras_low, RAS_LOW);
        chk(cas_n == 1'b1, "R3", "CAS rises with RAS", int'(cas_n), 1);
        hi_cnt = 0;
        seen_rise = 1'b1;
      end
      if (prev_cas && !cas_n && seen_rise)
        chk(hi_cnt >= PRECHG, "R4", "precharge before next CAS", hi_cnt, PRECHG);
      if (!ras_n) ras_low++;
      if (ras_n && cas_n) hi_cnt++;
      if (cas_n) cas_lead = 0;
      else if (ras_n) cas_lead++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_falls(input int n);
    repeat (n) @(fall_ev);
  endtask

  task automatic wait_ras_high();
    do @(negedge clk); while (!ras_n);
  endtask

  task automatic push_wake();
    for (int i = 0; i < WAKE_CYC; i++) exp_q.push_back(1'b0);
  endtask

  task automatic check_burst(input int n, input string req);
    int t0;
    wait_falls(1);
    t0 = fall_cyc;
    for (int i = 1; i < n; i++) begin
      wait_falls(1);
      chk(fall_cyc - t0 == B2B, req, "back-to-back spacing", fall_cyc - t0, B2B);
      t0 = fall_cyc;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (PAUSE_CYC * 0 + 60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finish (actual %0d expected %0d)", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int t0;
    wait_cyc(3);
    // R1: reset state
    chk(ras_n && cas_n, "R1", "strobes idle in reset", int'(ras_n && cas_n), 1);
    chk(!ref_req && !init_done && !pend_ovf, "R1", "req/ready/ovf low in reset",
        int'(ref_req || init_done || pend_ovf), 0);
    rst_n = 1'b1;
    // R1: exact pause length
    wait_cyc(PAUSE_CYC - 1);
    chk(ref_req == 1'b0, "R1", "ref_req low at end of pause", int'(ref_req), 0);
    wait_cyc(1);
    chk(ref_req == 1'b1, "R1", "ref_req rises after pause", int'(ref_req), 1);
    // R5, R10: grant withheld
    wait_cyc(30);
    chk(n_fall == 0, "R5", "no RAS without grant", n_fall, 0);
    chk(ref_req == 1'b1, "R10", "request held while wake-up waits", int'(ref_req), 1);
    // R2: wake-up burst
    push_wake();
    ref_gnt = 1'b1;
    wait_falls(WAKE_CYC);
    chk(init_done == 1'b0, "R2", "not ready during last wake-up", int'(init_done), 0);
    wait_cyc(15);
    chk(init_done == 1'b1, "R2", "ready after wake-up", int'(init_done), 1);
    chk(exp_q.size() == 0, "R2", "all wake-up cycles seen", exp_q.size(), 0);
    // R6: periodic spacing
    wait_falls(1);
    t0 = fall_cyc;
    for (int i = 0; i < 2; i++) begin
      wait_falls(1);
      chk(fall_cyc - t0 == REFI, "R6", "refresh spacing", fall_cyc - t0, REFI);
      t0 = fall_cyc;
    end
    // R7: three missed ticks drained back to back
    wait_falls(1);
    wait_ras_high();
    ref_gnt = 1'b0;
    wait_cyc(190);
    chk(ref_req == 1'b1, "R10", "request while refreshes queued", int'(ref_req), 1);
    chk(pend_ovf == 1'b0, "R8", "no overflow at three queued", int'(pend_ovf), 0);
    ref_gnt = 1'b1;
    check_burst(3, "R7");
    // R8: five missed ticks overflow a four-deep queue
    wait_falls(1);
    wait_ras_high();
    ref_gnt = 1'b0;
    wait_cyc(310);
    chk(pend_ovf == 1'b1, "R8", "overflow flag set", int'(pend_ovf), 1);
    ref_gnt = 1'b1;
    check_burst(PEND_MAX, "R8");
    wait_cyc(20);
    chk(pend_ovf == 1'b1, "R8", "overflow flag sticky", int'(pend_ovf), 1);
    // R9: long idle stretch forces a new wake-up burst
    wait_falls(1);
    wait_ras_high();
    ref_gnt = 1'b0;
    wait_cyc(470);
    chk(init_done == 1'b1, "R9", "still ready before idle limit", int'(init_done), 1);
    wait_cyc(40);
    chk(init_done == 1'b0, "R9", "ready dropped after idle limit", int'(init_done), 0);
    push_wake();
    ref_gnt = 1'b1;
    wait_falls(WAKE_CYC);
    wait_cyc(15);
    chk(init_done == 1'b1, "R9", "ready again after new wake-up", int'(init_done), 1);
    chk(exp_q.size() == 0, "R9", "all rerun wake-up cycles seen", exp_q.size(), 0);
    wait_cyc(80);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule